// File: doc/BRIEF.md
# Dual-Clock Mailbox Bridge

This block moves single 36-bit command words between two ports that run on unrelated clocks, beside the bulk data queues rather than through them. Mailbox 1 is loaded from port A and read at port B. Mailbox 2 is loaded from port B and read at port A. Each mailbox holds one word and has an active-low occupancy flag, high when the slot is free and low while a word waits to be read. The flag is seen on both sides of the clock boundary. The writing side sees it at once. The reading side sees it a short, bounded time later.

Each port has a select, a direction bit, an enable and a mailbox pick. When the mailbox pick is high, an enabled write stores the port's input word in the outgoing mailbox and an enabled read consumes the incoming mailbox. A word is kept until the writer has seen it consumed, so a second write before that is dropped. Reading does not alter the stored word. Each port drives a registered output word. It shows either the queue word presented at that port or the incoming mailbox, and it comes with an output-enable that models the bus driver.

Top module: `mbx_bridge`

## Requirements
- R1: On a rising clk_a edge with cs_a=1, wr_a=1 (1 = write, 0 = read), en_a=1, sel_a=1 (1 = mailbox, 0 = queue) and mb1_vacant_a=1, mailbox 1 stores din_a.
- R2: On a rising clk_b edge with cs_b=1, wr_b=1, en_b=1, sel_b=1 and mb2_vacant_b=1, mailbox 2 stores din_b.
- R3: An accepted write drives the writer-side flag (mb1_vacant_a or mb2_vacant_b) low in the same edge. Low means an unread word is held.
- R4: A write attempt while the writer-side flag is low is ignored: the stored word is unchanged and the flag stays low.
- R5: After an accepted write, the reader-side flag (mb1_vacant_b or mb2_vacant_a) goes low within three rising edges of the reader's clock.
- R6: A read with cs=1, wr=0, en=1, sel=1 on the reading port while its reader-side flag is low raises that flag on the same edge. The writer-side flag returns high within three rising edges of the writer's clock.
- R7: Reading a mailbox leaves its word unchanged. Only an accepted write alters it.
- R8: One edge after sampling, dout_a shows the mailbox 2 word when sel_a=1 and qword_a when sel_a=0. dout_b shows the mailbox 1 word or qword_b in the same way. This holds regardless of en and wr.
- R9: One edge after sampling, oe_a (oe_b) is 1 exactly when cs_a=1 and wr_a=0 (cs_b=1 and wr_b=0).
- R10: While the synchronous active-high resets rst_a and rst_b are held, both mailbox words clear to zero, all four flags read high, and dout and oe clear to zero.
- R11: A mailbox read on the writing port never releases that port's outgoing mailbox. Only a read on the opposite port does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Synchronous active-high reset, port A domain |
| cs_a | input | 1 | Port A select |
| wr_a | input | 1 | Port A direction, 1 write, 0 read |
| en_a | input | 1 | Port A transfer enable |
| sel_a | input | 1 | Port A mailbox pick, 1 mailbox, 0 queue |
| din_a | input | 36 | Port A write word |
| qword_a | input | 36 | Queue word offered at port A |
| dout_a | output | 36 | Registered port A output word |
| oe_a | output | 1 | Port A output enable |
| mb1_vacant_a | output | 1 | Mailbox 1 free flag, port A domain, active-low full |
| mb2_vacant_a | output | 1 | Mailbox 2 free flag as seen in port A domain |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Synchronous active-high reset, port B domain |
| cs_b | input | 1 | Port B select |
| wr_b | input | 1 | Port B direction, 1 write, 0 read |
| en_b | input | 1 | Port B transfer enable |
| sel_b | input | 1 | Port B mailbox pick, 1 mailbox, 0 queue |
| din_b | input | 36 | Port B write word |
| qword_b | input | 36 | Queue word offered at port B |
| dout_b | output | 36 | Registered port B output word |
| oe_b | output | 1 | Port B output enable |
| mb1_vacant_b | output | 1 | Mailbox 1 free flag as seen in port B domain |
| mb2_vacant_b | output | 1 | Mailbox 2 free flag, port B domain, active-low full |

## Verification
Random words are sent in random directions. Each transfer is followed at once by a second write carrying a different word, and the word that is read back tells whether the blocked write leaked into storage. The output path is driven with random queue words and the mailbox pick toggled while the enable is low. This separates a mux fault from a side effect of a read. Directed cases cover the empty state after reset, repeated reads that must return the same word, and mailbox reads on the writing port that must not free its outgoing slot.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef struct packed {
    logic cs;
    logic wr;
    logic en;
    logic sel;
  } port_ctl_t;

  function automatic logic mbx_wr_hit(port_ctl_t c);
    return c.cs & c.wr & c.en & c.sel;
  endfunction

  function automatic logic mbx_rd_hit(port_ctl_t c);
    return c.cs & ~c.wr & c.en & c.sel;
  endfunction

  function automatic logic port_drive(port_ctl_t c);
    return c.cs & ~c.wr;
  endfunction

endpackage

// File: rtl/mbx_sync2.sv
module mbx_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
  parameter int W         = 36,
  parameter int SYNC_STG  = 2
) (
  input  logic         clk_w,
  input  logic         rst_w,
  input  logic         wr_req,
  input  logic [W-1:0] wr_data,
  output logic         vacant_w,
  output logic [W-1:0] word,
  input  logic         clk_r,
  input  logic         rst_r,
  input  logic         rd_req,
  output logic         vacant_r
);
  logic wr_tgl, ack_seen, rd_tgl, wr_seen;
  logic busy_w, pend_r, accept;

  // writer domain
  assign busy_w   = wr_tgl ^ ack_seen;
  assign vacant_w = ~busy_w;
  assign accept   = wr_req & ~busy_w;

  always_ff @(posedge clk_w) begin
    if (rst_w) begin
      wr_tgl <= 1'b0;
      word   <= '0;
    end else if (accept) begin
      wr_tgl <= ~wr_tgl;
      word   <= wr_data;
    end
  end

  mbx_sync2 #(.STAGES(SYNC_STG)) u_ack_sync (
    .clk(clk_w), .rst(rst_w), .d(rd_tgl), .q(ack_seen)
  );

  // reader domain
  mbx_sync2 #(.STAGES(SYNC_STG)) u_req_sync (
    .clk(clk_r), .rst(rst_r), .d(wr_tgl), .q(wr_seen)
  );

  assign pend_r   = wr_seen ^ rd_tgl;
  assign vacant_r = ~pend_r;

  always_ff @(posedge clk_r) begin
    if (rst_r)                rd_tgl <= 1'b0;
    else if (rd_req & pend_r) rd_tgl <= ~rd_tgl;
  end

  // R3: accepted write marks the slot occupied
  p_accept_lowers_r3: assert property (@(posedge clk_w) disable iff (rst_w)
    (wr_req && vacant_w) |=> !vacant_w);

  // R4: write into an occupied slot leaves the word alone
  p_blocked_write_r4: assert property (@(posedge clk_w) disable iff (rst_w)
    (wr_req && !vacant_w) |=> $stable(word));

  // R7: only an accepted write moves the word
  p_word_stable_r7: assert property (@(posedge clk_w) disable iff (rst_w)
    !(wr_req && vacant_w) |=> $stable(word));

  // R6: a read of a pending word frees the reader-side view
  p_release_r6: assert property (@(posedge clk_r) disable iff (rst_r)
    (rd_req && !vacant_r) |=> vacant_r);

  // R10: reset empties the slot
  p_reset_w_r10: assert property (@(posedge clk_w)
    rst_w |=> (vacant_w && word == '0));
  p_reset_r_r10: assert property (@(posedge clk_r)
    rst_r |=> vacant_r);
endmodule

// File: rtl/mbx_port.sv
module mbx_port
  import mbx_pkg::*;
#(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst,
  input  port_ctl_t    ctl,
  input  logic [W-1:0] q_word,
  input  logic [W-1:0] mbx_word,
  output logic [W-1:0] dout,
  output logic         oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
      oe   <= 1'b0;
    end else begin
      dout <= ctl.sel ? mbx_word : q_word;
      oe   <= port_drive(ctl);
    end
  end

  // R9: driver enabled only after a selected read
  p_oe_needs_read_r9: assert property (@(posedge clk) disable iff (rst)
    (!ctl.cs || ctl.wr) |=> !oe);

  // R8: mailbox pick routes the incoming mailbox word
  p_mux_mailbox_r8: assert property (@(posedge clk) disable iff (rst)
    ctl.sel |=> dout == $past(mbx_word));

  // R8: queue pick routes the queue word
  p_mux_queue_r8: assert property (@(posedge clk) disable iff (rst)
    !ctl.sel |=> dout == $past(q_word));
endmodule

// File: rtl/mbx_bridge.sv
module mbx_bridge
  import mbx_pkg::*;
#(
  parameter int W        = 36,
  parameter int SYNC_STG = 2
) (
  input  logic         clk_a,
  input  logic         rst_a,
  input  logic         cs_a,
  input  logic         wr_a,
  input  logic         en_a,
  input  logic         sel_a,
  input  logic [W-1:0] din_a,
  input  logic [W-1:0] qword_a,
  output logic [W-1:0] dout_a,
  output logic         oe_a,
  output logic         mb1_vacant_a,
  output logic         mb2_vacant_a,
  input  logic         clk_b,
  input  logic         rst_b,
  input  logic         cs_b,
  input  logic         wr_b,
  input  logic         en_b,
  input  logic         sel_b,
  input  logic [W-1:0] din_b,
  input  logic [W-1:0] qword_b,
  output logic [W-1:0] dout_b,
  output logic         oe_b,
  output logic         mb1_vacant_b,
  output logic         mb2_vacant_b
);
  port_ctl_t    ctl_a, ctl_b;
  logic [W-1:0] mb1_word, mb2_word;

  assign ctl_a = '{cs: cs_a, wr: wr_a, en: en_a, sel: sel_a};
  assign ctl_b = '{cs: cs_b, wr: wr_b, en: en_b, sel: sel_b};

  // mailbox 1: A writes, B reads
  mbx_channel #(.W(W), .SYNC_STG(SYNC_STG)) u_mb1 (
    .clk_w(clk_a), .rst_w(rst_a), .wr_req(mbx_wr_hit(ctl_a)),
    .wr_data(din_a), .vacant_w(mb1_vacant_a), .word(mb1_word),
    .clk_r(clk_b), .rst_r(rst_b), .rd_req(mbx_rd_hit(ctl_b)),
    .vacant_r(mb1_vacant_b)
  );

  // mailbox 2: B writes, A reads
  mbx_channel #(.W(W), .SYNC_STG(SYNC_STG)) u_mb2 (
    .clk_w(clk_b), .rst_w(rst_b), .wr_req(mbx_wr_hit(ctl_b)),
    .wr_data(din_b), .vacant_w(mb2_vacant_b), .word(mb2_word),
    .clk_r(clk_a), .rst_r(rst_a), .rd_req(mbx_rd_hit(ctl_a)),
    .vacant_r(mb2_vacant_a)
  );

  mbx_port #(.W(W)) u_port_a (
    .clk(clk_a), .rst(rst_a), .ctl(ctl_a), .q_word(qword_a),
    .mbx_word(mb2_word), .dout(dout_a), .oe(oe_a)
  );

  mbx_port #(.W(W)) u_port_b (
    .clk(clk_b), .rst(rst_b), .ctl(ctl_b), .q_word(qword_b),
    .mbx_word(mb1_word), .dout(dout_b), .oe(oe_b)
  );

  // R11: a mailbox read on port A never frees mailbox 1
  p_no_self_release_r11: assert property (@(posedge clk_a) disable iff (rst_a)
    (mbx_rd_hit(ctl_a) && !mb1_vacant_a && !mbx_wr_hit(ctl_a)) |=> !mb1_vacant_a
      || $past(mb1_vacant_b));
endmodule

// File: tb/test_mbx_bridge.sv
`timescale 1ns/1ps
module test_mbx_bridge;
  localparam int W = 36;
  localparam int CLK_A_PERIOD = 10;
  localparam int CLK_B_PERIOD = 13;

  logic clk_a = 0, clk_b = 0;
  logic rst_a, rst_b;
  logic cs_a, wr_a, en_a, sel_a, cs_b, wr_b, en_b, sel_b;
  logic [W-1:0] din_a, qword_a, din_b, qword_b, dout_a, dout_b;
  logic oe_a, oe_b, mb1_vacant_a, mb2_vacant_a, mb1_vacant_b, mb2_vacant_b;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [W-1:0] exp_mb1, exp_mb2;

  always #(CLK_A_PERIOD/2) clk_a = ~clk_a;
  always #(CLK_B_PERIOD/2.0) clk_b = ~clk_b;

  mbx_bridge #(.W(W)) i_mbx_bridge (.*);

  function automatic logic [W-1:0] exp_out(bit sel, logic [W-1:0] mbx, logic [W-1:0] q);
    return sel ? mbx : q;
  endfunction

  function automatic logic [W-1:0] rnd_word();
    return {$urandom(), $urandom()} & {W{1'b1}};
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic a_step(); @(posedge clk_a); #1; endtask
  task automatic b_step(); @(posedge clk_b); #1; endtask

  task automatic a_idle(); cs_a = 0; wr_a = 0; en_a = 0; sel_a = 0; endtask
  task automatic b_idle(); cs_b = 0; wr_b = 0; en_b = 0; sel_b = 0; endtask

  task automatic a_write(logic [W-1:0] d);
    cs_a = 1; wr_a = 1; en_a = 1; sel_a = 1; din_a = d; a_step(); a_idle();
  endtask
  task automatic b_write(logic [W-1:0] d);
    cs_b = 1; wr_b = 1; en_b = 1; sel_b = 1; din_b = d; b_step(); b_idle();
  endtask
  task automatic a_read_mbx(); cs_a = 1; wr_a = 0; en_a = 1; sel_a = 1; a_step(); a_idle(); endtask
  task automatic b_read_mbx(); cs_b = 1; wr_b = 0; en_b = 1; sel_b = 1; b_step(); b_idle(); endtask
  task automatic a_peek(bit s); cs_a = 1; wr_a = 0; en_a = 0; sel_a = s; a_step(); a_idle(); endtask
  task automatic b_peek(bit s); cs_b = 1; wr_b = 0; en_b = 0; sel_b = s; b_step(); b_idle(); endtask

  // which: 0 mb1_vacant_a, 1 mb1_vacant_b, 2 mb2_vacant_a, 3 mb2_vacant_b
  function automatic logic flag(int which);
    case (which)
      0: return mb1_vacant_a;
      1: return mb1_vacant_b;
      2: return mb2_vacant_a;
      default: return mb2_vacant_b;
    endcase
  endfunction

  task automatic poll(int which, logic want, int max_edges, string req);
    for (int i = 0; i < max_edges && flag(which) !== want; i++) begin
      if (which == 0 || which == 2) a_step(); else b_step();
    end
    chk(req, flag(which), want);
  endtask

  task automatic xfer_a2b(logic [W-1:0] d);
    logic [W-1:0] other = ~d;
    a_write(d); exp_mb1 = d;
    chk("R3 mb1 flag after write", mb1_vacant_a, 0);
    a_write(other);
    chk("R4 mb1 flag after blocked write", mb1_vacant_a, 0);
    poll(1, 0, 3, "R5 mb1 reader flag");
    b_read_mbx();
    chk("R1/R4 mb1 word at port B", dout_b, exp_mb1);
    chk("R6 mb1 reader flag released", mb1_vacant_b, 1);
    chk("R9 oe_b on read", oe_b, 1);
    poll(0, 1, 3, "R6 mb1 writer flag released");
    b_peek(1);
    chk("R7 mb1 reread", dout_b, exp_mb1);
  endtask

  task automatic xfer_b2a(logic [W-1:0] d);
    logic [W-1:0] other = ~d;
    b_write(d); exp_mb2 = d;
    chk("R3 mb2 flag after write", mb2_vacant_b, 0);
    b_write(other);
    chk("R4 mb2 flag after blocked write", mb2_vacant_b, 0);
    poll(2, 0, 3, "R5 mb2 reader flag");
    a_read_mbx();
    chk("R2/R4 mb2 word at port A", dout_a, exp_mb2);
    chk("R6 mb2 reader flag released", mb2_vacant_a, 1);
    chk("R9 oe_a on read", oe_a, 1);
    poll(3, 1, 3, "R6 mb2 writer flag released");
    a_peek(1);
    chk("R7 mb2 reread", dout_a, exp_mb2);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_a = 1; rst_b = 1; a_idle(); b_idle();
    din_a = '0; din_b = '0; qword_a = '0; qword_b = '0;
    exp_mb1 = '0; exp_mb2 = '0;
    repeat (3) a_step();
    repeat (3) b_step();
    chk("R10 oe_a reset", oe_a, 0);
    chk("R10 dout_b reset", dout_b, '0);
    rst_a = 0; rst_b = 0;
    a_step(); b_step();
    chk("R10 mb1_vacant_a", mb1_vacant_a, 1);
    chk("R10 mb1_vacant_b", mb1_vacant_b, 1);
    chk("R10 mb2_vacant_a", mb2_vacant_a, 1);
    chk("R10 mb2_vacant_b", mb2_vacant_b, 1);
    a_peek(1); chk("R10 mb2 word zero", dout_a, '0);
    b_peek(1); chk("R10 mb1 word zero", dout_b, '0);

    // R11: reads on port A do not free mailbox 1
    a_write(36'hA5A5_0F0F_3);
    exp_mb1 = 36'hA5A5_0F0F_3;
    repeat (4) a_read_mbx();
    chk("R11 mb1 still held after port A reads", mb1_vacant_a, 0);
    poll(1, 0, 3, "R11 mb1 reader view still pending");
    b_read_mbx();
    chk("R1 directed word", dout_b, exp_mb1);
    poll(0, 1, 3, "R6 directed release");

    // directed boundary words
    xfer_a2b('0);
    xfer_b2a({W{1'b1}});

    // random transfers and mux checks
    for (int n = 0; n < 40; n++) begin
      logic [W-1:0] d = rnd_word();
      bit s = $urandom_range(0, 1);
      if ($urandom_range(0, 1)) xfer_a2b(d); else xfer_b2a(d);
      qword_a = rnd_word(); qword_b = rnd_word();
      a_peek(s);
      chk("R8 port A mux", dout_a, exp_out(s, exp_mb2, qword_a));
      b_peek(!s);
      chk("R8 port B mux", dout_b, exp_out(!s, exp_mb1, qword_b));
      cs_a = $urandom_range(0, 1); wr_a = $urandom_range(0, 1); sel_a = 0;
      a_step();
      chk("R9 oe_a pattern", oe_a, cs_a & ~wr_a);
      a_idle(); a_step();
      chk("R9 oe_a idle", oe_a, 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_a);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule